// File: doc/BRIEF.md
# Decision-Feedback Slicer Datapath

This block equalizes a stream of signed, quantized line samples, one per bit time. Before each sample is sliced, the block subtracts from it an estimate of the inter-symbol interference left by earlier bits. It forms that estimate from its own recent decisions. The five most recent decisions are kept in a shift register. Each one adds its tap weight when it was a 1, and subtracts the weight when it was a 0. The corrected sample is clipped to the sample range, and the slicer turns it into a bit.

The tap weights come from a flat configuration bus. When adaptation is enabled, a sign-sign LMS engine takes over the weights and moves each one by a single step per equalized bit. Samples arrive on a valid/ready stream, and results leave on another valid/ready stream. A result stalled at the output stops new samples from being taken. Once a result has been presented, it is held unchanged until the consumer takes it.

Top module: `dfe_eq`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The first four samples accepted after reset produce no result. Each accepted sample from the fifth onward produces exactly one result.
- R3: The weight for the decision made k bits earlier (k = 1..5) is `tap_cfg[(k-1)*6 +: 6]`, a two's-complement value. The feedback is the sum over k of +w_k when that decision was 1 and -w_k when it was 0. The corrected value is the sample minus the feedback.
- R4: The decision `out_bit` is 1 exactly when the corrected value is greater than or equal to zero.
- R5: A corrected value below -128 is reported as -128, and one above 127 is reported as 127. The decision is taken on the clipped value.
- R6: The result for a sample accepted at a clock edge appears on `out_bit` and `out_eq` (8-bit two's complement), with `out_valid` high, right after that same edge.
- R7: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_bit` and `out_eq` hold their values. `out_valid` drops only after a cycle with `out_ready` high.
- R8: With `adapt_en` low, the block uses the weights on `tap_cfg`. A change takes effect for samples accepted at least one full cycle after it.
- R9: With `adapt_en` high, every sample that produces a result also updates each weight. The error is the corrected value minus +64 when the decision was 1, or minus -64 when it was 0. Weight w_k rises by 1 when the sign of the error equals the sign of decision k (1 is positive, 0 is negative). It falls by 1 when the two signs differ, and it stays put when the error is zero.
- R10: During adaptation the weights stay within -32 and +31.
- R11: Samples that produce no result (R2) leave the weights unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample is present |
| in_ready | output | 1 | Block takes the sample at this edge |
| in_sample | input | 8 | Signed input sample |
| tap_cfg | input | 30 | Five signed 6-bit weights; field k-1 serves the decision k bits back |
| adapt_en | input | 1 | Enables sign-sign weight adaptation |
| out_valid | output | 1 | A result is present |
| out_ready | input | 1 | Consumer takes the result at this edge |
| out_bit | output | 1 | Sliced decision |
| out_eq | output | 8 | Clipped corrected sample |

## Verification
The feedback is driven with pseudo-random samples under several fixed weight sets. A one-hot weight set catches a wrong tap-to-delay mapping. Mixed-sign weights catch a sign inversion of the decision term. Full-scale samples under maximum weights push the corrected value past both clip limits, which separates correct saturation from wraparound. Adaptation runs long stretches from zero weights and from weights at the limits, which exposes step direction, the zero-error case, clamping and any update made during warm-up. A held output under back-pressure shows that a stalled result is neither lost nor overwritten.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
  typedef enum logic [1:0] {
    ERR_ZERO = 2'd0,
    ERR_POS  = 2'd1,
    ERR_NEG  = 2'd2
  } err_sign_e;
endpackage

// File: rtl/dfe_fb_sum.sv
module dfe_fb_sum #(
  parameter int NTAP = 5,
  parameter int WW   = 6,
  parameter int SUMW = 10
) (
  input  logic [NTAP-1:0]         hist,
  input  logic [NTAP*WW-1:0]      weights,
  output logic signed [SUMW-1:0]  fb
);
  localparam int EXT = SUMW - WW;

  logic signed [SUMW-1:0] term [NTAP];

  for (genvar gi = 0; gi < NTAP; gi++) begin : g_term
    logic [WW-1:0]          w_raw;
    logic signed [SUMW-1:0] w_ext;
    assign w_raw = weights[gi*WW +: WW];
    assign w_ext = $signed({{EXT{w_raw[WW-1]}}, w_raw});
    assign term[gi] = hist[gi] ? w_ext : -w_ext;
  end

  always_comb begin
    fb = '0;
    for (int i = 0; i < NTAP; i++) fb = fb + term[i];
  end
endmodule

// File: rtl/dfe_slicer.sv
module dfe_slicer
  import dfe_pkg::*;
#(
  parameter int SW    = 8,
  parameter int SUMW  = 10,
  parameter int LEVEL = 64
) (
  input  logic [SW-1:0]          sample,
  input  logic signed [SUMW-1:0] fb,
  output logic [SW-1:0]          eq,
  output logic                   dec,
  output err_sign_e              esign
);
  localparam int DW = ((SW > SUMW) ? SW : SUMW) + 1;
  localparam logic signed [DW-1:0] YMAX = DW'((2 ** (SW-1)) - 1);
  localparam logic signed [DW-1:0] YMIN = DW'(-(2 ** (SW-1)));
  localparam logic signed [DW-1:0] LVL  = DW'(LEVEL);

  logic signed [DW-1:0] diff;
  logic signed [DW-1:0] clip;
  logic signed [DW-1:0] err;

  always_comb begin
    diff = $signed({{(DW-SW){sample[SW-1]}}, sample}) -
           $signed({{(DW-SUMW){fb[SUMW-1]}}, fb});
    if (diff > YMAX)      clip = YMAX;
    else if (diff < YMIN) clip = YMIN;
    else                  clip = diff;
    eq  = clip[SW-1:0];
    dec = !clip[DW-1];
    err = dec ? (clip - LVL) : (clip + LVL);
    if (err == '0)        esign = ERR_ZERO;
    else if (err[DW-1])   esign = ERR_NEG;
    else                  esign = ERR_POS;
  end
endmodule

// File: rtl/dfe_tap_bank.sv
module dfe_tap_bank
  import dfe_pkg::*;
#(
  parameter int NTAP = 5,
  parameter int WW   = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NTAP*WW-1:0]    cfg,
  input  logic                  adapt_en,
  input  logic                  step_en,
  input  err_sign_e             esign,
  input  logic [NTAP-1:0]       hist,
  output logic [NTAP*WW-1:0]    weights
);
  localparam logic signed [WW:0] WMAX = (WW+1)'((2 ** (WW-1)) - 1);
  localparam logic signed [WW:0] WMIN = (WW+1)'(-(2 ** (WW-1)));

  for (genvar gi = 0; gi < NTAP; gi++) begin : g_tap
    logic [WW-1:0]        w_q;
    logic signed [1:0]    step;
    logic signed [WW:0]   sum_w;
    logic [WW-1:0]        w_next;

    always_comb begin
      step = 2'sd0;
      if (esign == ERR_POS)      step = hist[gi] ? 2'sd1 : -2'sd1;
      else if (esign == ERR_NEG) step = hist[gi] ? -2'sd1 : 2'sd1;
      sum_w = $signed({w_q[WW-1], w_q}) + $signed({{(WW-1){step[1]}}, step});
      if (sum_w > WMAX)      w_next = WMAX[WW-1:0];
      else if (sum_w < WMIN) w_next = WMIN[WW-1:0];
      else                   w_next = sum_w[WW-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)        w_q <= '0;
      else if (!adapt_en) w_q <= cfg[gi*WW +: WW];
      else if (step_en)  w_q <= w_next;
    end

    assign weights[gi*WW +: WW] = w_q;
  end
endmodule

// File: rtl/dfe_eq.sv
module dfe_eq
  import dfe_pkg::*;
#(
  parameter int NTAP  = 5,
  parameter int SW    = 8,
  parameter int WW    = 6,
  parameter int LEVEL = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [SW-1:0]        in_sample,
  input  logic [NTAP*WW-1:0]   tap_cfg,
  input  logic                 adapt_en,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_bit,
  output logic [SW-1:0]        out_eq
);
  localparam int SUMW = WW + $clog2(NTAP) + 1;
  localparam int CNTW = (NTAP > 2) ? $clog2(NTAP) : 1;
  localparam logic [CNTW-1:0] FILL_LAST = CNTW'(NTAP-1);

  logic [NTAP-1:0]        hist_q;
  logic [CNTW-1:0]        fill_q;
  logic                   warm;
  logic                   accept;
  logic [NTAP*WW-1:0]     weights;
  logic signed [SUMW-1:0] fb;
  logic [SW-1:0]          eq_c;
  logic                   dec_c;
  err_sign_e              esign;

  assign warm     = (fill_q == FILL_LAST);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  dfe_tap_bank #(.NTAP(NTAP), .WW(WW)) u_taps (
    .clk(clk), .rst_n(rst_n), .cfg(tap_cfg), .adapt_en(adapt_en),
    .step_en(accept && warm), .esign(esign), .hist(hist_q),
    .weights(weights)
  );

  dfe_fb_sum #(.NTAP(NTAP), .WW(WW), .SUMW(SUMW)) u_fb (
    .hist(hist_q), .weights(weights), .fb(fb)
  );

  dfe_slicer #(.SW(SW), .SUMW(SUMW), .LEVEL(LEVEL)) u_slice (
    .sample(in_sample), .fb(fb), .eq(eq_c), .dec(dec_c), .esign(esign)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (accept) begin
      hist_q <= {hist_q[NTAP-2:0], dec_c};
      if (!warm) fill_q <= fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      out_eq    <= '0;
    end else if (accept && warm) begin
      out_valid <= 1'b1;
      out_bit   <= dec_c;
      out_eq    <= eq_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dfe_eq_chk.sv
module dfe_eq_chk #(
  parameter int NTAP = 5,
  parameter int SW   = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_bit,
  input logic [SW-1:0] out_eq
);
  int acc_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) acc_cnt <= 0;
    else if (in_valid && in_ready && acc_cnt < NTAP) acc_cnt <= acc_cnt + 1;
  end

  // R2
  warm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> acc_cnt >= NTAP);

  // R4
  slice_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_bit == !out_eq[SW-1]);

  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_eq)));

  // R7
  drain_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  // R7
  stall_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind dfe_eq dfe_eq_chk #(.NTAP(NTAP), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit), .out_eq(out_eq)
);

// File: tb/dfe_eq_tb.sv
`timescale 1ns/1ps
module dfe_eq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_sample = '0;
  logic [29:0] tap_cfg = '0;
  logic        adapt_en = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_bit;
  logic [7:0]  out_eq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int  m_w[5];
  int  m_cfg[5];
  bit  m_h[5];
  int  m_cnt;
  bit  m_adapt;
  int  lfsr = 32'h1d2c;

  always #2.5 clk = ~clk;

  dfe_eq u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .tap_cfg(tap_cfg), .adapt_en(adapt_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit), .out_eq(out_eq)
  );

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic int rnd();
    lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
    return (lfsr >> 8) % 256 - 128;
  endfunction

  task automatic model_step(input int x, output int y, output bit d, output bit v);
    int fb = 0;
    int e, s;
    for (int i = 0; i < 5; i++) fb += m_h[i] ? m_w[i] : -m_w[i];
    y = clampi(x - fb, -128, 127);
    d = (y >= 0);
    v = (m_cnt == 4);
    if (v && m_adapt) begin
      e = y - (d ? 64 : -64);
      s = (e > 0) ? 1 : ((e < 0) ? -1 : 0);
      for (int i = 0; i < 5; i++) m_w[i] = clampi(m_w[i] + s * (m_h[i] ? 1 : -1), -32, 31);
    end
    for (int i = 4; i > 0; i--) m_h[i] = m_h[i-1];
    m_h[0] = d;
    if (m_cnt < 4) m_cnt++;
  endtask

  task automatic send(input int x, input string req);
    int ey; bit ed, ev;
    model_step(x, ey, ed, ev);
    @(negedge clk);
    in_valid = 1'b1; in_sample = x[7:0];
    @(negedge clk);
    in_valid = 1'b0;
    if (ev) begin
      chk(req, out_valid === 1'b1, int'(out_valid), 1);
      chk(req, $signed(out_eq) == ey, int'($signed(out_eq)), ey);
      chk(req, out_bit === ed, int'(out_bit), int'(ed));
    end else begin
      chk({req, " R2"}, out_valid === 1'b0, int'(out_valid), 0);
    end
  endtask

  task automatic set_cfg(input int w0, input int w1, input int w2, input int w3, input int w4);
    @(negedge clk);
    m_cfg = '{w0, w1, w2, w3, w4};
    for (int i = 0; i < 5; i++) tap_cfg[i*6 +: 6] = m_cfg[i][5:0];
    @(negedge clk);
    @(negedge clk);
    if (!m_adapt) m_w = m_cfg;
  endtask

  task automatic set_adapt(input bit a);
    @(negedge clk);
    adapt_en = a; m_adapt = a;
    if (!a) begin
      @(negedge clk);
      m_w = m_cfg;
    end
  endtask

  // R1: reset state
  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    adapt_en = 1'b0; m_adapt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_h = '{0, 0, 0, 0, 0}; m_cnt = 0; m_w = m_cfg;
    @(negedge clk);
    chk("R1 out_valid", out_valid === 1'b0, int'(out_valid), 0);
    chk("R1 in_ready", in_ready === 1'b1, int'(in_ready), 1);
  endtask

  // R2: warm-up gate
  task automatic t_warmup();
    for (int i = 0; i < 6; i++) send(rnd(), "R2 warmup");
  endtask

  // R3 R4 R6 R8: fixed weights
  task automatic t_fixed();
    set_cfg(20, 0, 0, 0, 0);
    for (int i = 0; i < 30; i++) send(rnd(), "R3 tap1");
    set_cfg(0, 0, 0, 0, 17);
    for (int i = 0; i < 30; i++) send(rnd(), "R3 tap5");
    set_cfg(-13, 9, -5, 3, -2);
    for (int i = 0; i < 40; i++) send(rnd(), "R8 mixed");
    set_cfg(7, 7, 7, 7, 7);
    for (int i = 0; i < 20; i++) send((i % 3 == 0) ? 0 : rnd(), "R4 zero edge");
  endtask

  // R5: clipping both ends
  task automatic t_sat();
    set_cfg(31, 31, 31, 31, 31);
    for (int i = 0; i < 20; i++) send((i % 2) ? 127 : -128, "R5 clip max w");
    set_cfg(-32, -32, -32, -32, -32);
    for (int i = 0; i < 20; i++) send((i % 3) ? 127 : -128, "R5 clip min w");
  endtask

  // R7: back-pressure
  task automatic t_bp();
    int ya, yb; bit da, db, va, vb;
    int xa = rnd(); int xb = rnd();
    set_cfg(5, -3, 2, 0, 1);
    model_step(xa, ya, da, va);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_sample = xa[7:0];
    @(negedge clk);
    in_sample = xb[7:0];
    chk("R7 held valid", out_valid === 1'b1, int'(out_valid), 1);
    chk("R7 stall", in_ready === 1'b0, int'(in_ready), 0);
    repeat (3) @(negedge clk);
    chk("R7 held eq", $signed(out_eq) == ya, int'($signed(out_eq)), ya);
    chk("R7 held bit", out_bit === da, int'(out_bit), int'(da));
    chk("R7 stall still", in_ready === 1'b0, int'(in_ready), 0);
    model_step(xb, yb, db, vb);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 next eq", $signed(out_eq) == yb, int'($signed(out_eq)), yb);
    chk("R7 next bit", out_bit === db, int'(out_bit), int'(db));
    @(negedge clk);
    chk("R7 drained", out_valid === 1'b0, int'(out_valid), 0);
  endtask

  // R9 R11: adaptation from zero, starting at reset
  task automatic t_adapt();
    int prev = 1; int cur;
    set_cfg(0, 0, 0, 0, 0);
    t_reset();
    set_adapt(1);
    for (int i = 0; i < 300; i++) begin
      cur = (rnd() >= 0) ? 1 : 0;
      send(clampi((cur ? 60 : -60) + (prev ? 25 : -25) + rnd() / 16, -128, 127),
           (i < 4) ? "R11 warmup adapt" : "R9 adapt");
      prev = cur;
    end
    set_adapt(0);
  endtask

  // R10: adaptation at the limits
  task automatic t_adapt_sat();
    set_cfg(31, -32, 31, -32, 31);
    set_adapt(1);
    for (int i = 0; i < 200; i++) send((i % 4 < 2) ? 127 : -128, "R10 limit");
    set_adapt(0);
    set_cfg(-32, 31, -32, 31, -32);
    set_adapt(1);
    for (int i = 0; i < 200; i++) send(rnd(), "R10 limit rnd");
    set_adapt(0);
  endtask

  initial begin
    m_cfg = '{0, 0, 0, 0, 0};
    t_reset();
    t_warmup();
    t_fixed();
    t_sat();
    t_bp();
    t_adapt();
    t_adapt_sat();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule